// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits on the 32-bit host write path in front of a bank of 128-bit control registers and a 64-bit-word SRAM. Partial host writes are gathered, one dword per cycle, into a single shared holding stage. When every dword of the target has arrived, the block issues one atomic wide write on the matching commit port. Each commit port carries an aligned byte address, the full data word and a strobe that is high for one clock, in the cycle after the completing host write.

A few write-only descriptor-pointer registers repeat in every per-queue page. They follow a relaxed rule so that the host never has to lock around them. Writing their top dword always produces a commit. Lanes that are not held are then committed as zero. Writes to their lower dwords are discarded while the collector is busy with some other target. A single timer-command word in page 0 also empties the collector as a side effect. This models a quirk that software already has to tolerate.

Top module: `wide_write_collector`

## Requirements
- R1: Byte addresses below 0x80000 select 128-bit registers, aligned on 16 bytes. Address bits 3:2 pick the dword lane, and lane n lands in data bits 32n+31:32n. A register commits only when all four lanes are held, in any arrival order. The commit carries the 16-byte-aligned address and the data.
- R2: Byte addresses at or above 0x80000 select 64-bit SRAM words. Address bit 2 picks the lane, and lane 1 is bits 63:32. A word commits on the SRAM port once both lanes are held, with its 8-byte-aligned address.
- R3: Each commit strobe is high for exactly the one cycle after the completing write. The collector is empty after any commit, so a fresh full set of lanes is needed for the next commit of the same target.
- R4: A register or SRAM write to a different target than the one being collected restarts collection with only that lane. Earlier partial data never commits.
- R5: Writing a lane that is already held replaces its value and does not trigger an early commit.
- R6: A write to the top dword of a descriptor pointer (page offset 0x83C or 0xA1C, page stride 0x2000) always commits that register in the next cycle. If lanes 0 to 2 of the same register are held, they are included. Otherwise bits 95:0 are committed as zero.
- R7: A write to a lower dword of a descriptor pointer is discarded while the collector holds lanes of a different target. The held target and data are kept. When the collector is empty, or holds the same pointer, the lane is collected.
- R8: A write to byte address 0x420 (the timer command of page 0) empties the collector and commits nothing.
- R9: Synchronous active-low reset empties the collector and holds both commit strobes low.
- R10: A cycle with the write strobe low changes nothing and commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host dword write strobe |
| host_addr | input | 20 | Host byte address, bits 1:0 ignored |
| host_data | input | 32 | Host write data |
| reg_commit_valid | output | 1 | One-cycle strobe for a 128-bit register commit |
| reg_commit_addr | output | 20 | 16-byte-aligned register address |
| reg_commit_data | output | 128 | Register data, lane 0 in bits 31:0 |
| sram_commit_valid | output | 1 | One-cycle strobe for a 64-bit SRAM commit |
| sram_commit_addr | output | 20 | 8-byte-aligned SRAM word address |
| sram_commit_data | output | 64 | SRAM data, lane 0 in bits 31:0 |

## Verification
Two functions can land on the same edge: a forced descriptor commit and the loss of another target's partial data. This happens when the top dword of a descriptor pointer arrives while the collector holds lanes of some other register or SRAM word. It also happens when a timer-command clear lands just before the last lane of a target. Directed sequences build exactly these overlaps. The random phase draws from a small pool of addresses, so that interleaving, drops and clears occur often. Every cycle is judged against a bench-side model of the collector: strobe, address and data, all sampled in the cycle after the write.

// File: rtl/wcol_pkg.sv
// Shared types for the wide write collector.
// Assumes one host dword write per clock at most.
package wcol_pkg;

    // Class of a host write after address decode.
    typedef enum logic [2:0] {
        WK_REG      = 3'd0,  // lane of an ordinary wide register
        WK_SRAM     = 3'd1,  // lane of an SRAM word
        WK_DESC_LO  = 3'd2,  // lower lane of a descriptor pointer
        WK_DESC_TOP = 3'd3,  // top lane of a descriptor pointer
        WK_TIMER    = 3'd4   // page-0 timer command, clears the collector
    } wkind_t;

    // Actions chosen by the policy for the current cycle.
    typedef struct packed {
        logic store;      // add lane to the current collection
        logic restart;    // begin a new collection with this lane only
        logic clear;      // empty the collector at the end of the cycle
        logic fire_reg;   // issue a register commit
        logic fire_sram;  // issue an SRAM commit
        logic desc_full;  // descriptor commit carries held low lanes
    } wact_t;

endpackage

// File: rtl/wcol_decode.sv
// Address decoder: classifies a host byte address and derives its lane
// and aligned target base. Pure combinational logic.
// Assumes the SRAM window lies above all paged registers.
module wcol_decode
    import wcol_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          DWORD_W    = 32,
    parameter int          REG_LANES  = 4,
    parameter int          SRAM_LANES = 2,
    parameter int          PAGE_SHIFT = 13,
    parameter int unsigned SRAM_BASE  = 32'h8_0000,
    parameter int unsigned DESC_A_OFS = 32'h830,
    parameter int unsigned DESC_B_OFS = 32'hA10,
    parameter int unsigned TIMER_OFS  = 32'h420,
    localparam int LANE_W = $clog2(REG_LANES)
) (
    input  logic [ADDR_W-1:0] addr,
    output wkind_t            kind,
    output logic [LANE_W-1:0] lane,
    output logic [ADDR_W-1:0] base
);
    localparam int DW_LSB   = $clog2(DWORD_W / 8);
    localparam int ROW_LSB  = $clog2(REG_LANES * DWORD_W / 8);
    localparam int SRAM_LSB = $clog2(SRAM_LANES * DWORD_W / 8);
    localparam int ROW_W    = PAGE_SHIFT - ROW_LSB;
    localparam int TW_W     = ADDR_W - DW_LSB;

    localparam logic [ROW_W-1:0]  DA_ROW     = ROW_W'(DESC_A_OFS >> ROW_LSB);
    localparam logic [ROW_W-1:0]  DB_ROW     = ROW_W'(DESC_B_OFS >> ROW_LSB);
    localparam logic [TW_W-1:0]   TIMER_WORD = TW_W'(TIMER_OFS >> DW_LSB);
    localparam logic [ADDR_W-1:0] SRAM_LIM   = ADDR_W'(SRAM_BASE);
    localparam logic [LANE_W-1:0] TOP_LANE   = LANE_W'(REG_LANES - 1);

    logic in_sram;
    logic is_desc;
    logic is_timer;

    // Region and special-address detection.
    always_comb begin
        in_sram  = addr >= SRAM_LIM;
        is_desc  = !in_sram && ((addr[PAGE_SHIFT-1:ROW_LSB] == DA_ROW) ||
                                (addr[PAGE_SHIFT-1:ROW_LSB] == DB_ROW));
        is_timer = addr[ADDR_W-1:DW_LSB] == TIMER_WORD;
    end

    // Lane index and aligned base for the target region.
    always_comb begin
        if (in_sram) begin
            lane = LANE_W'(addr[SRAM_LSB-1:DW_LSB]);
            base = {addr[ADDR_W-1:SRAM_LSB], SRAM_LSB'(0)};
        end else begin
            lane = addr[ROW_LSB-1:DW_LSB];
            base = {addr[ADDR_W-1:ROW_LSB], ROW_LSB'(0)};
        end
    end

    // Kind selection; the timer word takes priority over all other decodes.
    always_comb begin
        if (is_timer)               kind = WK_TIMER;
        else if (in_sram)           kind = WK_SRAM;
        else if (is_desc)           kind = (lane == TOP_LANE) ? WK_DESC_TOP : WK_DESC_LO;
        else                        kind = WK_REG;
    end

endmodule

// File: rtl/wcol_policy.sv
// Collection policy: decides per cycle whether the write is stored,
// restarts collection, is dropped, clears, or completes a commit.
// Pure combinational logic. Assumes at most one write per cycle.
module wcol_policy
    import wcol_pkg::*;
#(
    parameter int REG_LANES  = 4,
    parameter int SRAM_LANES = 2,
    localparam int LANE_W = $clog2(REG_LANES)
) (
    input  logic                 wr,
    input  wkind_t               kind,
    input  logic [LANE_W-1:0]    lane,
    input  logic [REG_LANES-1:0] mask,
    input  logic                 same,
    output wact_t                act
);
    localparam logic [REG_LANES-1:0] REG_FULL  = '1;
    localparam logic [REG_LANES-1:0] SRAM_FULL = REG_LANES'((1 << SRAM_LANES) - 1);
    localparam logic [REG_LANES-1:0] LOW_FULL  = REG_FULL >> 1;

    logic                 busy;
    logic                 hit;
    logic [REG_LANES-1:0] lane_bit;
    logic [REG_LANES-1:0] after;
    logic [REG_LANES-1:0] need;

    // Occupancy terms and the lane mask after a store or restart.
    always_comb begin
        busy     = |mask;
        hit      = busy && same;
        lane_bit = REG_LANES'(1) << lane;
        after    = (hit ? mask : '0) | lane_bit;
        need     = (kind == WK_SRAM) ? SRAM_FULL : REG_FULL;
    end

    // Action selection by kind.
    always_comb begin
        act = '0;
        if (wr) begin
            unique case (kind)
                WK_TIMER: begin
                    act.clear = 1'b1;
                end
                WK_DESC_TOP: begin
                    act.fire_reg  = 1'b1;
                    act.clear     = 1'b1;
                    act.desc_full = hit && ((mask & LOW_FULL) == LOW_FULL);
                end
                WK_DESC_LO: begin
                    // dropped while another target is held
                    act.store   = hit;
                    act.restart = !busy;
                end
                default: begin
                    act.store   = hit;
                    act.restart = !hit;
                    if (after == need) begin
                        act.clear     = 1'b1;
                        act.fire_reg  = (kind == WK_REG);
                        act.fire_sram = (kind == WK_SRAM);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/wcol_lane_bank.sv
// Lane storage: one data register and one valid bit per dword lane.
// A restart keeps only the written lane valid; clear wins over set.
module wcol_lane_bank #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    store,
    input  logic                    restart,
    input  logic                    clear,
    input  logic [IDX_W-1:0]        lane,
    input  logic [LANE_W-1:0]       wdata,
    output logic [LANES-1:0]        mask,
    output logic [LANES*LANE_W-1:0] held
);
    logic [LANES-1:0] lane_bit;
    logic             take;

    // Decoded lane select and write enable.
    always_comb begin
        lane_bit = LANES'(1) << lane;
        take     = store || restart;
    end

    // Valid mask update.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (clear)   mask <= '0;
        else if (restart) mask <= lane_bit;
        else if (store)   mask <= mask | lane_bit;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Data register of one lane.
        always_ff @(posedge clk) begin
            if (!rst_n)                    held[g*LANE_W +: LANE_W] <= '0;
            else if (take && lane_bit[g])  held[g*LANE_W +: LANE_W] <= wdata;
        end
    end

endmodule

// File: rtl/wcol_commit.sv
// Commit output stage: registers both commit ports so each strobe is
// high for exactly one cycle after the deciding write.
module wcol_commit #(
    parameter int ADDR_W = 20,
    parameter int REG_W  = 128,
    parameter int SRAM_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_reg,
    input  logic              fire_sram,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  reg_data,
    input  logic [SRAM_W-1:0] sram_data,
    output logic              reg_valid,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [REG_W-1:0]  reg_q,
    output logic              sram_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [SRAM_W-1:0] sram_q
);
    // Register-port strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_valid <= 1'b0;
        else        reg_valid <= fire_reg;
    end

    // Register-port address and data, loaded only on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_addr <= '0;
            reg_q    <= '0;
        end else if (fire_reg) begin
            reg_addr <= addr;
            reg_q    <= reg_data;
        end
    end

    // SRAM-port strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) sram_valid <= 1'b0;
        else        sram_valid <= fire_sram;
    end

    // SRAM-port address and data, loaded only on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr <= '0;
            sram_q    <= '0;
        end else if (fire_sram) begin
            sram_addr <= addr;
            sram_q    <= sram_data;
        end
    end

endmodule

// File: rtl/wide_write_collector.sv
// Wide register write collector (top).
// Gathers 32-bit host writes into one shared collector and issues atomic
// 128-bit register or 64-bit SRAM commits. Descriptor-pointer registers
// commit on their top dword; a page-0 timer word clears the collector.
// Assumes one host write per cycle at most and dword-aligned addresses.
module wide_write_collector
    import wcol_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          DWORD_W    = 32,
    parameter int          REG_LANES  = 4,
    parameter int          SRAM_LANES = 2,
    parameter int          PAGE_SHIFT = 13,
    parameter int unsigned SRAM_BASE  = 32'h8_0000,
    parameter int unsigned DESC_A_OFS = 32'h830,
    parameter int unsigned DESC_B_OFS = 32'hA10,
    parameter int unsigned TIMER_OFS  = 32'h420,
    localparam int REG_W  = REG_LANES * DWORD_W,
    localparam int SRAM_W = SRAM_LANES * DWORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DWORD_W-1:0] host_data,
    output logic              reg_commit_valid,
    output logic [ADDR_W-1:0] reg_commit_addr,
    output logic [REG_W-1:0]  reg_commit_data,
    output logic              sram_commit_valid,
    output logic [ADDR_W-1:0] sram_commit_addr,
    output logic [SRAM_W-1:0] sram_commit_data
);
    localparam int LANE_W = $clog2(REG_LANES);
    localparam int LOW_W  = REG_W - DWORD_W;

    wkind_t              dec_kind;
    logic [LANE_W-1:0]   dec_lane;
    logic [ADDR_W-1:0]   dec_base;
    logic [REG_LANES-1:0] lane_mask;
    logic [REG_W-1:0]    lane_held;
    logic [REG_W-1:0]    merged;
    logic [REG_W-1:0]    reg_next;
    logic [ADDR_W-1:0]   tag_base;
    logic                tag_sram;
    logic                tag_same;
    wact_t               act;

    wcol_decode #(
        .ADDR_W(ADDR_W), .DWORD_W(DWORD_W), .REG_LANES(REG_LANES),
        .SRAM_LANES(SRAM_LANES), .PAGE_SHIFT(PAGE_SHIFT), .SRAM_BASE(SRAM_BASE),
        .DESC_A_OFS(DESC_A_OFS), .DESC_B_OFS(DESC_B_OFS), .TIMER_OFS(TIMER_OFS)
    ) u_decode (
        .addr(host_addr),
        .kind(dec_kind),
        .lane(dec_lane),
        .base(dec_base)
    );

    // Whether the decoded target matches the held target tag.
    always_comb begin
        tag_same = (tag_base == dec_base) && (tag_sram == (dec_kind == WK_SRAM));
    end

    wcol_policy #(
        .REG_LANES(REG_LANES), .SRAM_LANES(SRAM_LANES)
    ) u_policy (
        .wr(host_wr),
        .kind(dec_kind),
        .lane(dec_lane),
        .mask(lane_mask),
        .same(tag_same),
        .act(act)
    );

    // Target tag: base address and region of the current collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_base <= '0;
            tag_sram <= 1'b0;
        end else if (act.restart) begin
            tag_base <= dec_base;
            tag_sram <= (dec_kind == WK_SRAM);
        end
    end

    wcol_lane_bank #(
        .LANES(REG_LANES), .LANE_W(DWORD_W)
    ) u_lanes (
        .clk(clk),
        .rst_n(rst_n),
        .store(act.store),
        .restart(act.restart),
        .clear(act.clear),
        .lane(dec_lane),
        .wdata(host_data),
        .mask(lane_mask),
        .held(lane_held)
    );

    // Held lanes with the current write's lane substituted.
    always_comb begin
        merged = lane_held;
        merged[dec_lane*DWORD_W +: DWORD_W] = host_data;
    end

    // Register commit data: a partial descriptor commit zeroes its low lanes.
    always_comb begin
        if (dec_kind == WK_DESC_TOP && !act.desc_full)
            reg_next = {host_data, LOW_W'(0)};
        else
            reg_next = merged;
    end

    wcol_commit #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .SRAM_W(SRAM_W)
    ) u_commit (
        .clk(clk),
        .rst_n(rst_n),
        .fire_reg(act.fire_reg),
        .fire_sram(act.fire_sram),
        .addr(dec_base),
        .reg_data(reg_next),
        .sram_data(merged[SRAM_W-1:0]),
        .reg_valid(reg_commit_valid),
        .reg_addr(reg_commit_addr),
        .reg_q(reg_commit_data),
        .sram_valid(sram_commit_valid),
        .sram_addr(sram_commit_addr),
        .sram_q(sram_commit_data)
    );

endmodule

// File: rtl/wcol_checker.sv
// Property checker for the wide write collector, attached by bind.
// Observes ports only and decodes the special addresses independently.
module wcol_checker #(
    parameter int          ADDR_W     = 20,
    parameter int          PAGE_SHIFT = 13,
    parameter int unsigned SRAM_BASE  = 32'h8_0000,
    parameter int unsigned DESC_A_OFS = 32'h830,
    parameter int unsigned DESC_B_OFS = 32'hA10,
    parameter int unsigned TIMER_OFS  = 32'h420
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic              reg_commit_valid,
    input logic [ADDR_W-1:0] reg_commit_addr,
    input logic              sram_commit_valid,
    input logic [ADDR_W-1:0] sram_commit_addr
);
    localparam int PW = PAGE_SHIFT - 2;
    localparam logic [PW-1:0]       TOP_A = PW'((DESC_A_OFS + 12) >> 2);
    localparam logic [PW-1:0]       TOP_B = PW'((DESC_B_OFS + 12) >> 2);
    localparam logic [ADDR_W-3:0]   TMR   = (ADDR_W-2)'(TIMER_OFS >> 2);
    localparam logic [ADDR_W-1:0]   SLIM  = ADDR_W'(SRAM_BASE);

    logic desc_top_wr;
    logic timer_wr;

    // Independent decode of forcing and clearing writes.
    always_comb begin
        desc_top_wr = host_wr && (host_addr < SLIM) &&
                      ((host_addr[PAGE_SHIFT-1:2] == TOP_A) ||
                       (host_addr[PAGE_SHIFT-1:2] == TOP_B));
        timer_wr    = host_wr && (host_addr[ADDR_W-1:2] == TMR);
    end

    a_r1_reg_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        reg_commit_valid |-> (reg_commit_addr[3:0] == 4'h0));

    a_r2_sram_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        sram_commit_valid |-> (sram_commit_addr[2:0] == 3'h0) && (sram_commit_addr >= SLIM));

    a_r3_commit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_commit_valid || sram_commit_valid) |-> $past(host_wr));

    a_r3_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_commit_valid && sram_commit_valid));

    a_r6_desc_top_commits: assert property (@(posedge clk) disable iff (!rst_n)
        desc_top_wr |=> reg_commit_valid);

    a_r8_timer_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        timer_wr |=> !reg_commit_valid && !sram_commit_valid);

    a_r10_idle_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> !reg_commit_valid && !sram_commit_valid);

endmodule

bind wide_write_collector wcol_checker #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SRAM_BASE(SRAM_BASE),
    .DESC_A_OFS(DESC_A_OFS), .DESC_B_OFS(DESC_B_OFS), .TIMER_OFS(TIMER_OFS)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .host_wr(host_wr),
    .host_addr(host_addr),
    .reg_commit_valid(reg_commit_valid),
    .reg_commit_addr(reg_commit_addr),
    .sram_commit_valid(sram_commit_valid),
    .sram_commit_addr(sram_commit_addr)
);

// File: tb/sim_wide_write_collector.sv
`timescale 1ns/1ps
module sim_wide_write_collector;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr = 1'b0;
    logic [19:0]  host_addr = '0;
    logic [31:0]  host_data = '0;
    logic         reg_commit_valid;
    logic [19:0]  reg_commit_addr;
    logic [127:0] reg_commit_data;
    logic         sram_commit_valid;
    logic [19:0]  sram_commit_addr;
    logic [63:0]  sram_commit_data;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model of the collector
    logic [3:0]  m_mask = '0;
    logic [19:0] m_base = '0;
    logic        m_sram = 1'b0;
    logic [31:0] m_lane [4];

    always #4 clk = ~clk;

    wide_write_collector u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .reg_commit_valid(reg_commit_valid),
        .reg_commit_addr(reg_commit_addr), .reg_commit_data(reg_commit_data),
        .sram_commit_valid(sram_commit_valid), .sram_commit_addr(sram_commit_addr),
        .sram_commit_data(sram_commit_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_sram_a(input logic [19:0] a);
        return a >= 20'h80000;
    endfunction

    function automatic bit is_desc_a(input logic [19:0] a);
        return !is_sram_a(a) && (a[12:4] == 9'h083 || a[12:4] == 9'h0A1);
    endfunction

    // One cycle: predict, drive, then sample after the clock edge.
    task automatic step(input bit wr, input logic [19:0] a, input logic [31:0] d,
                        input string tag);
        bit           e_rv = 0, e_sv = 0;
        logic [19:0]  e_ra = '0, e_sa = '0;
        logic [127:0] e_rd = '0;
        logic [63:0]  e_sd = '0;
        bit           sr, busy, same;
        logic [1:0]   ln;
        logic [19:0]  bs;
        if (wr) begin
            sr   = is_sram_a(a);
            ln   = sr ? {1'b0, a[2]} : a[3:2];
            bs   = sr ? {a[19:3], 3'b0} : {a[19:4], 4'b0};
            busy = |m_mask;
            same = (bs == m_base) && (sr == m_sram);
            if (a[19:2] == 18'h108) begin
                m_mask = '0;
            end else if (is_desc_a(a) && ln == 2'd3) begin
                e_rv = 1; e_ra = bs;
                if (busy && same && m_mask[2:0] == 3'b111)
                    e_rd = {d, m_lane[2], m_lane[1], m_lane[0]};
                else
                    e_rd = {d, 96'b0};
                m_mask = '0;
            end else if (is_desc_a(a)) begin
                if (!busy || same) begin
                    if (!busy) begin m_base = bs; m_sram = 1'b0; end
                    m_lane[ln] = d; m_mask[ln] = 1'b1;
                end
            end else begin
                if (!(busy && same)) begin m_mask = '0; m_base = bs; m_sram = sr; end
                m_lane[ln] = d; m_mask[ln] = 1'b1;
                if (sr && m_mask == 4'b0011) begin
                    e_sv = 1; e_sa = bs; e_sd = {m_lane[1], m_lane[0]}; m_mask = '0;
                end else if (!sr && m_mask == 4'b1111) begin
                    e_rv = 1; e_ra = bs;
                    e_rd = {m_lane[3], m_lane[2], m_lane[1], m_lane[0]};
                    m_mask = '0;
                end
            end
        end
        host_wr = wr; host_addr = a; host_data = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
        chk(reg_commit_valid == e_rv, tag, "reg valid", 128'(reg_commit_valid), 128'(e_rv));
        chk(sram_commit_valid == e_sv, tag, "sram valid", 128'(sram_commit_valid), 128'(e_sv));
        if (e_rv && reg_commit_valid) begin
            chk(reg_commit_addr == e_ra, tag, "reg addr", 128'(reg_commit_addr), 128'(e_ra));
            chk(reg_commit_data == e_rd, tag, "reg data", reg_commit_data, e_rd);
        end
        if (e_sv && sram_commit_valid) begin
            chk(sram_commit_addr == e_sa, tag, "sram addr", 128'(sram_commit_addr), 128'(e_sa));
            chk(sram_commit_data == e_sd, tag, "sram data", 128'(sram_commit_data), 128'(e_sd));
        end
    endtask

    task automatic wipe();
        step(1'b1, 20'h00420, 32'h0, "R8");
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_lane[i] = '0;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R9: strobes low in and after reset
        chk(!reg_commit_valid && !sram_commit_valid, "R9", "reset valids",
            128'({reg_commit_valid, sram_commit_valid}), 128'(0));
        rst_n = 1'b1;
        step(1'b0, 20'h0, 32'h0, "R9");

        // R1: out-of-order lanes of one register
        step(1'b1, 20'h00108, 32'hAAAA0002, "R1");
        step(1'b1, 20'h00100, 32'hAAAA0000, "R1");
        step(1'b1, 20'h0010C, 32'hAAAA0003, "R1");
        step(1'b1, 20'h00104, 32'hAAAA0001, "R1");
        // R3: after commit, three lanes alone do not commit
        step(1'b1, 20'h00100, 32'h1, "R3");
        step(1'b1, 20'h00104, 32'h2, "R3");
        step(1'b1, 20'h00108, 32'h3, "R3");
        wipe();
        // R5: rewritten lane replaces value, no early commit
        step(1'b1, 20'h00200, 32'h11111111, "R5");
        step(1'b1, 20'h00200, 32'h22222222, "R5");
        step(1'b1, 20'h00204, 32'h33333333, "R5");
        step(1'b1, 20'h00208, 32'h44444444, "R5");
        step(1'b1, 20'h0020C, 32'h55555555, "R5");
        // R4: interleaved target restarts collection
        step(1'b1, 20'h00300, 32'hA0, "R4");
        step(1'b1, 20'h00304, 32'hA1, "R4");
        step(1'b1, 20'h00400, 32'hB0, "R4");
        step(1'b1, 20'h00404, 32'hB1, "R4");
        step(1'b1, 20'h00408, 32'hB2, "R4");
        step(1'b1, 20'h0040C, 32'hB3, "R4");
        step(1'b1, 20'h00308, 32'hA2, "R4");
        step(1'b1, 20'h0030C, 32'hA3, "R4");
        wipe();
        // R2: SRAM word, lanes in reverse order
        step(1'b1, 20'h8000C, 32'hC1, "R2");
        step(1'b1, 20'h80008, 32'hC0, "R2");
        // R6: lone top dword on page 2, then full pointer on page 2
        step(1'b1, 20'h04A1C, 32'hD00D, "R6");
        step(1'b1, 20'h04830, 32'hE0, "R6");
        step(1'b1, 20'h04834, 32'hE1, "R6");
        step(1'b1, 20'h04838, 32'hE2, "R6");
        step(1'b1, 20'h0483C, 32'hE3, "R6");
        // R6 with another target partially held: forced commit and loss coincide
        step(1'b1, 20'h00500, 32'hF0, "R6");
        step(1'b1, 20'h0283C, 32'hF9, "R6");
        step(1'b1, 20'h00504, 32'hF1, "R6");
        wipe();
        // R7: descriptor lower dword dropped while another target held
        step(1'b1, 20'h00600, 32'h60, "R7");
        step(1'b1, 20'h00604, 32'h61, "R7");
        step(1'b1, 20'h06834, 32'h99, "R7");
        step(1'b1, 20'h00608, 32'h62, "R7");
        step(1'b1, 20'h0060C, 32'h63, "R7");
        // R8: timer clear before last lane
        step(1'b1, 20'h00700, 32'h70, "R8");
        step(1'b1, 20'h00704, 32'h71, "R8");
        step(1'b1, 20'h00708, 32'h72, "R8");
        step(1'b1, 20'h00420, 32'h0, "R8");
        step(1'b1, 20'h0070C, 32'h73, "R8");
        wipe();
        // R10: idle cycle with completing address does nothing
        step(1'b1, 20'h80010, 32'h80, "R10");
        step(1'b0, 20'h80014, 32'h81, "R10");
        step(1'b1, 20'h80014, 32'h82, "R10");

        // random phase over a small address pool
        for (int i = 0; i < 4000; i++) begin
            int unsigned  pick = $urandom_range(0, 14);
            logic [1:0]   ln = 2'($urandom_range(0, 3));
            logic [19:0]  a;
            case (pick)
                0, 1, 2:  a = 20'h00100 + 20'(ln) * 4;
                3, 4:     a = 20'h02240 + 20'(ln) * 4;
                5, 6:     a = 20'h00830 + 20'(ln) * 4;
                7, 8:     a = 20'h04A10 + 20'(ln) * 4;
                9, 10:    a = 20'h80008 + 20'(ln[0]) * 4;
                11, 12:   a = 20'h80FF0 + 20'(ln[0]) * 4;
                13:       a = 20'h00420;
                default:  a = 20'h02420;
            endcase
            step($urandom_range(0, 7) != 0, a, $urandom, "RND");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule